// File: doc/BRIEF.md
# Multi-digit BCD decimal adder

This block adds two packed decimal operands of `DIGITS` digits each, plus a single incoming carry. It returns a packed decimal sum of the same width and one outgoing decimal carry. The block is purely combinational and has no clock or reset. The result is valid once the inputs have settled through the logic.

Each digit position is one stage, built from two 4-bit look-ahead adders. The first adder forms the raw binary sum of the two digits and the carry from the stage below it. A detect term then marks the raw sums from ten to nineteen: the adder's carry out, or the top raw bit together with either of the next two bits. When the detect term is set, the second adder adds six to the raw sum and its own carry out is discarded. The detect term is also the decimal carry into the next stage up. Inside each 4-bit adder, every carry is a flat sum of products of the generate terms, the propagate terms and the incoming carry. The stages are chained, so a carry can travel from digit 0 to the top digit.

Operands are packed with the least significant digit in bits [3:0]. Digit `i` occupies bits [4i+3:4i]. Input digits above nine are outside the contract, and the outputs for them are undefined.

Top module: `bcd_dec_adder`

## Requirements
- R1: In any digit stage whose raw sum (digit A + digit B + incoming carry) is 0 to 9, the output digit equals that raw sum and no carry passes to the next digit.
- R2: In any digit stage whose raw sum is 10 to 19, the output digit equals the raw sum minus ten and a carry of one passes to the next digit.
- R3: The carry out of the top digit is 1 exactly when the decimal value of A plus B plus `carry_in` is at least 10^DIGITS. The two boundary cases are 5000 + 5000, which gives a carry, and 4999 + 5000, which does not.
- R4: The carry out of digit i is the carry into digit i+1. A sum of 9 + 1 placed in digit i alone gives 0 in digit i and 1 in digit i+1, for every position.
- R5: For valid operands, `sum_o` is the packed decimal form of (A + B + `carry_in`) mod 10^DIGITS.
- R6: Digit 0 occupies bits [3:0], and digit i occupies bits [4i+3:4i], in both operands and in the sum.
- R7: `carry_in` adds exactly one unit to the least significant digit. With both operands zero, the sum is 1 when `carry_in` is 1 and 0 when it is 0, and the output carry is 0 in both cases.
- R8: For valid operands, every output digit lies between 0 and 9.
- R9: A carry can ripple through every digit. All nines plus zero with `carry_in` at 1 gives a sum of all zeros and an output carry of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| add_a | input | 4*DIGITS | First packed decimal operand, digit 0 in bits [3:0] |
| add_b | input | 4*DIGITS | Second packed decimal operand, same packing |
| carry_in | input | 1 | Decimal carry into digit 0 |
| sum_o | output | 4*DIGITS | Packed decimal sum |
| carry_o | output | 1 | Decimal carry out of the top digit |

## Verification
Every pair of single digits is applied to digit 0, with `carry_in` at both values. This sweep separates the sums that pass through unchanged from those that take the add-six correction, including the edge between nine and ten. A sum of 9 + 1 is then walked through each digit position in turn. This shows that each stage's carry reaches its own upper neighbour and no other digit. Random multi-digit operands, the all-nines ripple case and the 5000 + 5000 and 4999 + 5000 pair check the full decimal value and the outgoing carry against an integer model.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
    localparam int NIBBLE_W  = 4;
    localparam int DEC_LIMIT = 9;
    localparam logic [NIBBLE_W-1:0] FIX_SIX = 4'd6;
    typedef logic [NIBBLE_W-1:0] nibble_t;
endpackage

// File: rtl/bcd_cla4.sv
module bcd_cla4 #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_out
);
    logic [W-1:0] gen_t;
    logic [W-1:0] prp_t;
    logic [W:0]   cy;

    assign gen_t = op_a & op_b;
    assign prp_t = op_a ^ op_b;

    // Each carry is formed as a flat OR of product terms:
    // c_in & p[0..i], and g[j] & p[j+1..i] for every j <= i.
    always_comb begin
        cy[0] = c_in;
        for (int i = 0; i < W; i++) begin
            logic acc;
            acc = 1'b0;
            for (int j = -1; j <= i; j++) begin
                logic prod;
                prod = (j < 0) ? c_in : gen_t[j];
                for (int k = j + 1; k <= i; k++) begin
                    prod = prod & prp_t[k];
                end
                acc = acc | prod;
            end
            cy[i+1] = acc;
        end
    end

    assign sum   = prp_t ^ cy[W-1:0];
    assign c_out = cy[W];
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
    import bcd_add_pkg::*;
(
    input  nibble_t dig_a,
    input  nibble_t dig_b,
    input  logic    dig_cin,
    output nibble_t dig_sum,
    output logic    dig_cout
);
    nibble_t raw_z;
    logic    raw_k;
    logic    need_fix;
    nibble_t fix_addend;
    logic    corr_cout_unused;

    bcd_cla4 #(.W(NIBBLE_W)) u_raw (
        .op_a  (dig_a),
        .op_b  (dig_b),
        .c_in  (dig_cin),
        .sum   (raw_z),
        .c_out (raw_k)
    );

    // Raw sums of ten to nineteen: the binary carry, or 1x1x / 11xx patterns.
    assign need_fix   = raw_k | (raw_z[3] & raw_z[2]) | (raw_z[3] & raw_z[1]);
    assign fix_addend = need_fix ? FIX_SIX : '0;

    bcd_cla4 #(.W(NIBBLE_W)) u_fix (
        .op_a  (raw_z),
        .op_b  (fix_addend),
        .c_in  (1'b0),
        .sum   (dig_sum),
        .c_out (corr_cout_unused)
    );

    assign dig_cout = need_fix;
endmodule

// File: rtl/bcd_dec_adder.sv
module bcd_dec_adder #(
    parameter int DIGITS = 4,
    localparam int BUS_W = 4 * DIGITS
) (
    input  logic [BUS_W-1:0] add_a,
    input  logic [BUS_W-1:0] add_b,
    input  logic             carry_in,
    output logic [BUS_W-1:0] sum_o,
    output logic             carry_o
);
    logic [DIGITS:0] dec_cy;

    assign dec_cy[0] = carry_in;

    for (genvar g = 0; g < DIGITS; g++) begin : g_stage
        bcd_digit_stage u_stage (
            .dig_a    (add_a[4*g +: 4]),
            .dig_b    (add_b[4*g +: 4]),
            .dig_cin  (dec_cy[g]),
            .dig_sum  (sum_o[4*g +: 4]),
            .dig_cout (dec_cy[g+1])
        );
    end

    assign carry_o = dec_cy[DIGITS];
endmodule

// File: rtl/bcd_dec_adder_chk.sv
module bcd_dec_adder_chk #(
    parameter int DIGITS = 4,
    localparam int BUS_W = 4 * DIGITS
) (
    input logic [BUS_W-1:0] add_a,
    input logic [BUS_W-1:0] add_b,
    input logic             carry_in,
    input logic [BUS_W-1:0] sum_o,
    input logic             carry_o
);
    logic in_ok;
    logic dig_bad;
    logic rng_bad;
    logic d0_bad;
    logic ref_cy;

    always_comb begin
        int run;
        int tot;
        int d0raw;
        in_ok   = 1'b1;
        dig_bad = 1'b0;
        rng_bad = 1'b0;
        run     = carry_in ? 1 : 0;
        for (int i = 0; i < DIGITS; i++) begin
            if (add_a[4*i +: 4] > 4'd9 || add_b[4*i +: 4] > 4'd9) in_ok = 1'b0;
            if (sum_o[4*i +: 4] > 4'd9) rng_bad = 1'b1;
            tot = int'(add_a[4*i +: 4]) + int'(add_b[4*i +: 4]) + run;
            if (int'(sum_o[4*i +: 4]) != (tot >= 10 ? tot - 10 : tot)) dig_bad = 1'b1;
            run = (tot >= 10) ? 1 : 0;
        end
        ref_cy = (run != 0);
        d0raw  = int'(add_a[3:0]) + int'(add_b[3:0]) + (carry_in ? 1 : 0);
        d0_bad = (d0raw <= 9) && (int'(sum_o[3:0]) != d0raw);

        // R8: output digits stay decimal
        p_digit_range_r8: assert (!in_ok || !rng_bad)
            else $error("output digit above nine");
        // R4: each digit agrees with a carry chained from the digit below
        p_chain_digits_r4: assert (!in_ok || !dig_bad)
            else $error("digit mismatch along carry chain");
        // R3: top carry matches the chained decimal carry
        p_carry_out_r3: assert (!in_ok || carry_o == ref_cy)
            else $error("output carry mismatch");
        // R1: small digit-0 sums pass through unchanged
        p_pass_through_r1: assert (!in_ok || !d0_bad)
            else $error("digit 0 pass-through mismatch");
        // R7: zero addend and no carry leaves the operand untouched
        p_identity_r7: assert (!in_ok || add_b != '0 || carry_in || (sum_o == add_a && !carry_o))
            else $error("identity addition changed the operand");
    end
endmodule

bind bcd_dec_adder bcd_dec_adder_chk #(.DIGITS(DIGITS)) chk_i (
    .add_a    (add_a),
    .add_b    (add_b),
    .carry_in (carry_in),
    .sum_o    (sum_o),
    .carry_o  (carry_o)
);

// File: tb/bcd_dec_adder_tb.sv
module bcd_dec_adder_tb_top;
    localparam int N = 4;
    localparam int BW = 4 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BW-1:0] add_a = '0;
    logic [BW-1:0] add_b = '0;
    logic carry_in = 1'b0;
    logic [BW-1:0] sum_o;
    logic carry_o;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_dec_adder #(.DIGITS(N)) dut_i (
        .add_a(add_a), .add_b(add_b), .carry_in(carry_in),
        .sum_o(sum_o), .carry_o(carry_o)
    );

    function automatic longint pow10(int e);
        longint r = 1;
        for (int i = 0; i < e; i++) r = r * 10;
        return r;
    endfunction

    function automatic longint to_int(logic [BW-1:0] x);
        longint r = 0;
        for (int i = N - 1; i >= 0; i--) r = r * 10 + longint'(x[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [BW-1:0] to_bcd(longint v);
        logic [BW-1:0] r = '0;
        longint t = v;
        for (int i = 0; i < N; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic apply_check(input string tag, input logic [BW-1:0] a,
                               input logic [BW-1:0] b, input logic ci);
        longint tot;
        logic [BW-1:0] exp_s;
        logic exp_c;
        @(negedge clk);
        add_a = a; add_b = b; carry_in = ci;
        tot   = to_int(a) + to_int(b) + (ci ? 1 : 0);
        exp_c = (tot >= pow10(N));
        exp_s = to_bcd(tot % pow10(N));
        @(posedge clk);
        #1;
        n_tests++;
        if (sum_o !== exp_s || carry_o !== exp_c) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h ci=%b got sum=%h carry=%b expected sum=%h carry=%b",
                     tag, a, b, ci, sum_o, carry_o, exp_s, exp_c);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] ra;
        logic [BW-1:0] rb;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands give zero
        apply_check("R7 zero", '0, '0, 1'b0);
        apply_check("R7 carry_in one", '0, '0, 1'b1);
        // Exhaustive single-digit sweep on digit 0; digit 1 carries the decimal carry
        for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
                for (int c = 0; c < 2; c++)
                    apply_check((x + y + c) >= 10 ? "R2 corrected digit" : "R1 pass-through digit",
                                BW'(x), BW'(y), c[0]);
        // Digit packing and per-position carry hop
        apply_check("R6 packing", BW'(16'h0005), '0, 1'b0);
        apply_check("R6 packing upper", BW'(16'h3070), BW'(16'h0602), 1'b0);
        for (int p = 0; p < N; p++)
            apply_check("R4 carry hop", BW'(9) << (4 * p), BW'(1) << (4 * p), 1'b0);
        // Top carry boundary
        apply_check("R3 carry boundary set", to_bcd(pow10(N) / 2), to_bcd(pow10(N) / 2), 1'b0);
        apply_check("R3 carry boundary clear", to_bcd(pow10(N) / 2 - 1), to_bcd(pow10(N) / 2), 1'b0);
        apply_check("R3 max sum", to_bcd(pow10(N) - 1), to_bcd(pow10(N) - 1), 1'b1);
        // Full ripple
        apply_check("R9 full ripple", to_bcd(pow10(N) - 1), '0, 1'b1);
        // Random multi-digit operands
        for (int t = 0; t < 400; t++) begin
            for (int d = 0; d < N; d++) begin
                ra[4*d +: 4] = 4'($urandom % 10);
                rb[4*d +: 4] = 4'($urandom % 10);
            end
            apply_check("R5 R8 random", ra, rb, 1'($urandom % 2));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule